// File: doc/BRIEF.md
# Banked Memory Address Translator

This block sits between a 24-bit CPU address bus and the storage behind it, and turns each request into a physical location. That location is a byte index into a RAM of 8 MB plus two 64 KB "fast" banks, or an index into a 256 KB ROM, or nothing at all. The mapping depends on a set of one-bit toggles. The CPU flips a toggle by touching a fixed address in the `$C0xx` page; the block receives that touch as a strobe plus the low address byte. The mapping also depends on a shadow register and a state register, which the CPU loads directly.

The toggles steer the first 64 KB bank piece by piece into a second, auxiliary 64 KB bank. Reads and writes are steered separately. The bottom 512 bytes are steered as a group. The text page and, optionally, the graphics page can be steered together through a page-select toggle. A write that lands in either of the first two banks, inside a video page whose shadowing is on, produces a second write target in the matching fast bank. Both targets appear in the same response, so the memory model can commit them together.

Requests enter on a valid/ready port and leave after one register stage on a second valid/ready port. A request moves only when valid and ready are both high at a clock edge. A response is held unchanged for as long as the consumer keeps ready low. The toggle strobe and the two register loads are plain control inputs.

Top module: `bank_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, `state_rdata` is 8'h00, all toggles are clear and the shadow register is zero, which leaves the upper overlay on and both video shadows on.
- R2: With the overlay off (shadow bit 6 set) and no steering active, banks 8'h00 to 8'h7F map linearly to RAM: `rsp_kind` is 1 (RAM) and `rsp_index` equals the address.
- R3: Banks 8'hFC to 8'hFF map to ROM: `rsp_kind` is 2 and `rsp_index` is the address minus 24'hFC0000. A write there has `rsp_we` 0.
- R4: With the overlay on (shadow bit 6 clear), in banks 8'h00, 8'h01, 8'hE0 and 8'hE1, offsets 16'hD000 to 16'hFFFF map to the top 64 KB of ROM (index 24'h30000 plus offset, `rsp_we` 0). Offsets 16'hC000 to 16'hCFFF give `rsp_kind` 0 (none) and index 0.
- R5: Bank 8'hE0 maps to RAM index 24'h800000 plus offset, and bank 8'hE1 maps to 24'h810000 plus offset. Writes there raise no shadow target.
- R6: A write whose RAM target is in bank 0 or 1, at 16'h0400 to 16'h07FF with shadow bit 0 clear or at 16'h2000 to 16'h3FFF with shadow bit 1 clear, also raises `rsp_sh_we`, with `rsp_sh_index` equal to 24'h800000 plus 64 KB times that bank plus the offset. This comes in the same response as `rsp_we`. Reads never raise it.
- R7: Strobe byte 8'h05 sets and 8'h04 clears write-steering (state bit 4). Strobe byte 8'h03 sets and 8'h02 clears read-steering (state bit 5). They send bank-0 offsets 16'h0200 to 16'hBFFF to the auxiliary bank (RAM index plus 24'h10000).
- R8: Bank-0 offsets 16'h0000 to 16'h01FF ignore read- and write-steering. Strobe byte 8'h09 sets and 8'h08 clears the low-area toggle (state bit 7), which sends this range to the auxiliary bank for both directions.
- R9: Strobe 8'h01/8'h00 sets/clears page pairing, 8'h55/8'h54 sets/clears page select (state bit 6), and 8'h57/8'h56 sets/clears the graphics toggle. With pairing set, bank-0 offsets 16'h0400 to 16'h07FF go to the auxiliary bank exactly when page select is set, for reads and writes, whatever the steering toggles say. With the graphics toggle also set, 16'h2000 to 16'h3FFF follow the same rule.
- R10: A bank-0 video-page write that is steered to the auxiliary bank has its shadow target in bank 8'hE1 (24'h810000 plus offset), never in 8'hE0.
- R11: A toggle strobe changes the mapping from the clock edge that follows it. A request accepted on the same edge as the strobe uses the old setting.
- R12: A `state_we` pulse loads all eight state bits. The upper four bits drive the toggles named in R7 to R9, `state_rdata` returns all eight bits, and a load wins over a strobe in the same cycle.
- R13: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request appears on the response port one cycle later, and a response stays stable while `rsp_ready` is low.
- R14: Banks 8'h80 to 8'hDF and 8'hE2 to 8'hFB give `rsp_kind` 0, index 0 and no enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request will be taken at this edge |
| req_addr | input | 24 | CPU address, bank in the top byte |
| req_we | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Translation present |
| rsp_ready | input | 1 | Consumer takes the translation |
| rsp_kind | output | 2 | 0 none, 1 RAM, 2 ROM |
| rsp_index | output | 24 | RAM or ROM byte index |
| rsp_we | output | 1 | Primary RAM write enable |
| rsp_sh_we | output | 1 | Shadow write enable into a fast bank |
| rsp_sh_index | output | 24 | RAM index of the shadow write |
| sw_stb | input | 1 | Toggle-page access strobe |
| sw_sel | input | 8 | Low address byte of that access |
| shadow_we | input | 1 | Load the shadow register |
| shadow_wdata | input | 8 | Shadow value: bit 0 text shadow off, bit 1 graphics shadow off, bit 6 overlay off |
| state_we | input | 1 | Load the state register |
| state_wdata | input | 8 | State value |
| state_rdata | output | 8 | State register contents |

## Verification
Each steering mode gets a probe address in each bank-0 region: the low 512 bytes, the text page, the graphics page, the general area and the `$C000`+ area. Each probe is sent as both a read and a write. This separates the read path from the write path and shows which rule has priority over which. The same addresses are repeated under several shadow values (zero, a graphics-only inhibit, overlay-only inhibit, everything off), so a shadow target that wrongly appears or goes missing is visible. A strobe that arrives on the same edge as a request, together with a stalled consumer holding a second request back, fixes the cycle on which settings and data move.

// File: rtl/bank_xlate_pkg.sv
`timescale 1ns/1ps
package bank_xlate_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_ROM  = 2'd2
  } tgt_e;

  // Bit order is visible on state_rdata: first member is bit 7.
  typedef struct packed {
    logic       low_alt;
    logic       pg_sel;
    logic       rd_aux;
    logic       wr_aux;
    logic [3:0] spare;
  } state_t;

endpackage

// File: rtl/bank_xlate_switches.sv
`timescale 1ns/1ps
module bank_xlate_switches
  import bank_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_stb,
  input  logic [7:0] sw_sel,
  input  logic       shadow_we,
  input  logic [7:0] shadow_wdata,
  input  logic       state_we,
  input  logic [7:0] state_wdata,
  output state_t     st_q,
  output logic       pair_q,
  output logic       hires_q,
  output logic       no_text_sh,
  output logic       no_hgr_sh,
  output logic       no_ovl
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= '0;
      pair_q     <= 1'b0;
      hires_q    <= 1'b0;
      no_text_sh <= 1'b0;
      no_hgr_sh  <= 1'b0;
      no_ovl     <= 1'b0;
    end else begin
      if (sw_stb) begin
        case (sw_sel)
          8'h00: pair_q     <= 1'b0;
          8'h01: pair_q     <= 1'b1;
          8'h02: st_q.rd_aux  <= 1'b0;
          8'h03: st_q.rd_aux  <= 1'b1;
          8'h04: st_q.wr_aux  <= 1'b0;
          8'h05: st_q.wr_aux  <= 1'b1;
          8'h08: st_q.low_alt <= 1'b0;
          8'h09: st_q.low_alt <= 1'b1;
          8'h54: st_q.pg_sel  <= 1'b0;
          8'h55: st_q.pg_sel  <= 1'b1;
          8'h56: hires_q    <= 1'b0;
          8'h57: hires_q    <= 1'b1;
          default: ;
        endcase
      end
      // A direct load comes later and therefore wins over a strobe.
      if (state_we) st_q <= state_t'(state_wdata);
      if (shadow_we) begin
        no_text_sh <= shadow_wdata[0];
        no_hgr_sh  <= shadow_wdata[1];
        no_ovl     <= shadow_wdata[6];
      end
    end
  end

  // R7: write-steering set strobe is visible on the next edge
  p_wraux_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stb && sw_sel == 8'h05 && !state_we |=> st_q.wr_aux);

  // R9: page select clear strobe is visible on the next edge
  p_page2_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stb && sw_sel == 8'h54 && !state_we |=> !st_q.pg_sel);

  // R12: direct load replaces every state bit
  p_state_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |=> st_q == state_t'($past(state_wdata)));

endmodule

// File: rtl/bank_xlate_decode.sv
`timescale 1ns/1ps
module bank_xlate_decode
  import bank_xlate_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int IDX_W        = 24,
  parameter int LINEAR_BANKS = 128,
  parameter int ROM_BANKS    = 4,
  parameter int FAST_BANK    = 8'hE0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  state_t            st,
  input  logic              pair,
  input  logic              hires,
  input  logic              no_text_sh,
  input  logic              no_hgr_sh,
  input  logic              no_ovl,
  output tgt_e              kind,
  output logic [IDX_W-1:0]  idx,
  output logic              wen,
  output logic              sh_wen,
  output logic [IDX_W-1:0]  sh_idx
);

  localparam int OFF_W  = 16;
  localparam int BANK_W = ADDR_W - OFF_W;
  localparam logic [BANK_W-1:0] LIN_END   = BANK_W'(LINEAR_BANKS);
  localparam logic [BANK_W-1:0] ROM_FIRST = BANK_W'((1 << BANK_W) - ROM_BANKS);
  localparam logic [BANK_W-1:0] FAST_B    = BANK_W'(FAST_BANK);
  localparam logic [IDX_W-1:0]  FAST_BASE = IDX_W'(LINEAR_BANKS * 65536);
  localparam logic [IDX_W-1:0]  ROM_TOP   = IDX_W'((ROM_BANKS - 1) * 65536);

  logic [BANK_W-1:0] bank, pb;
  logic [OFF_W-1:0]  off;
  logic is_lin, is_fast, is_rom, ovl, in_low, in_text, in_hgr, aux, sh_region;

  assign bank    = addr[ADDR_W-1:OFF_W];
  assign off     = addr[OFF_W-1:0];
  assign is_lin  = bank < LIN_END;
  assign is_rom  = bank >= ROM_FIRST;
  assign is_fast = bank[BANK_W-1:1] == FAST_B[BANK_W-1:1];
  assign ovl     = !no_ovl && (bank[BANK_W-1:1] == '0 || is_fast);
  assign in_low  = off[15:9] == 7'd0;
  assign in_text = off[15:10] == 6'b000001;
  assign in_hgr  = off[15:13] == 3'b001;
  assign sh_region = (in_text && !no_text_sh) || (in_hgr && !no_hgr_sh);

  // Auxiliary steering of the first bank, highest priority first.
  always_comb begin
    if (in_low)                      aux = st.low_alt;
    else if (pair && in_text)        aux = st.pg_sel;
    else if (pair && hires && in_hgr) aux = st.pg_sel;
    else if (off < 16'hC000)         aux = we ? st.wr_aux : st.rd_aux;
    else                             aux = 1'b0;
  end

  assign pb = (bank == '0) ? BANK_W'(aux) : bank;

  always_comb begin
    kind   = TGT_NONE;
    idx    = '0;
    wen    = 1'b0;
    sh_wen = 1'b0;
    sh_idx = '0;
    if (is_rom) begin
      kind = TGT_ROM;
      idx  = IDX_W'({bank - ROM_FIRST, off});
    end else if (ovl && off >= 16'hD000) begin
      kind = TGT_ROM;
      idx  = ROM_TOP + IDX_W'(off);
    end else if (ovl && off[15:12] == 4'hC) begin
      kind = TGT_NONE;
    end else if (is_fast) begin
      kind = TGT_RAM;
      idx  = FAST_BASE + IDX_W'({bank[0], off});
      wen  = we;
    end else if (is_lin) begin
      kind = TGT_RAM;
      idx  = IDX_W'({pb, off});
      wen  = we;
      if (we && pb[BANK_W-1:1] == '0 && sh_region) begin
        sh_wen = 1'b1;
        sh_idx = FAST_BASE + IDX_W'({pb[0], off});
      end
    end
  end

endmodule

// File: rtl/bank_xlate_pipe.sv
`timescale 1ns/1ps
module bank_xlate_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R13: a stalled response does not move or vanish
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R13: an accepted request is presented one cycle later
  p_take_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));

endmodule

// File: rtl/bank_xlate.sv
`timescale 1ns/1ps
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int IDX_W        = 24,
  parameter int LINEAR_BANKS = 128,
  parameter int ROM_BANKS    = 4,
  parameter int FAST_BANK    = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_kind,
  output logic [IDX_W-1:0]  rsp_index,
  output logic              rsp_we,
  output logic              rsp_sh_we,
  output logic [IDX_W-1:0]  rsp_sh_index,
  input  logic              sw_stb,
  input  logic [7:0]        sw_sel,
  input  logic              shadow_we,
  input  logic [7:0]        shadow_wdata,
  input  logic              state_we,
  input  logic [7:0]        state_wdata,
  output logic [7:0]        state_rdata
);

  localparam int PAY_W = 2 + IDX_W + 1 + 1 + IDX_W;
  localparam logic [IDX_W-1:0] FAST_BASE = IDX_W'(LINEAR_BANKS * 65536);

  state_t st;
  logic pair, hires, no_text_sh, no_hgr_sh, no_ovl;
  tgt_e d_kind;
  logic [IDX_W-1:0] d_idx, d_sh_idx;
  logic d_wen, d_sh_wen;
  logic [PAY_W-1:0] pay_in, pay_out;

  bank_xlate_switches u_sw (
    .clk(clk), .rst_n(rst_n), .sw_stb(sw_stb), .sw_sel(sw_sel),
    .shadow_we(shadow_we), .shadow_wdata(shadow_wdata),
    .state_we(state_we), .state_wdata(state_wdata),
    .st_q(st), .pair_q(pair), .hires_q(hires),
    .no_text_sh(no_text_sh), .no_hgr_sh(no_hgr_sh), .no_ovl(no_ovl)
  );

  bank_xlate_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINEAR_BANKS(LINEAR_BANKS),
    .ROM_BANKS(ROM_BANKS), .FAST_BANK(FAST_BANK)
  ) u_dec (
    .addr(req_addr), .we(req_we), .st(st), .pair(pair), .hires(hires),
    .no_text_sh(no_text_sh), .no_hgr_sh(no_hgr_sh), .no_ovl(no_ovl),
    .kind(d_kind), .idx(d_idx), .wen(d_wen), .sh_wen(d_sh_wen), .sh_idx(d_sh_idx)
  );

  assign pay_in = {d_kind, d_idx, d_wen, d_sh_wen, d_sh_idx};

  bank_xlate_pipe #(.W(PAY_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pay_out)
  );

  assign {rsp_kind, rsp_index, rsp_we, rsp_sh_we, rsp_sh_index} = pay_out;
  assign state_rdata = st;

  // R3: a ROM target never carries a write enable
  p_rom_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == TGT_ROM |-> !rsp_we);

  // R6: a shadow write rides on a RAM primary write and lands in the fast banks
  p_shadow_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_sh_we |-> rsp_we && rsp_kind == TGT_RAM && rsp_sh_index >= FAST_BASE);

endmodule

// File: tb/test_bank_xlate.sv
`timescale 1ns/1ps
module test_bank_xlate;

  localparam logic [1:0] K_NONE = 2'd0, K_RAM = 2'd1, K_ROM = 2'd2;

  typedef struct {
    logic [1:0]  kind;
    logic [23:0] idx;
    logic        we;
    logic        sh;
    logic [23:0] sidx;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [23:0] req_addr = '0;
  logic sw_stb = 1'b0, shadow_we = 1'b0, state_we = 1'b0;
  logic [7:0] sw_sel = '0, shadow_wdata = '0, state_wdata = '0;
  wire req_ready, rsp_valid, rsp_we, rsp_sh_we;
  wire [1:0] rsp_kind;
  wire [23:0] rsp_index, rsp_sh_index;
  wire [7:0] state_rdata;

  int n_chk = 0, n_bad = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  bank_xlate i_bank_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_kind(rsp_kind), .rsp_index(rsp_index), .rsp_we(rsp_we), .rsp_sh_we(rsp_sh_we),
    .rsp_sh_index(rsp_sh_index), .sw_stb(sw_stb), .sw_sel(sw_sel),
    .shadow_we(shadow_we), .shadow_wdata(shadow_wdata),
    .state_we(state_we), .state_wdata(state_wdata), .state_rdata(state_rdata)
  );

  task automatic check(input logic ok, input string tag, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Scoreboard monitor: compares at the negedge before the handshake edge.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R13: got unexpected response idx=%h expected none", rsp_index);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_kind !== e.kind || rsp_index !== e.idx || rsp_we !== e.we ||
            rsp_sh_we !== e.sh || (e.sh && rsp_sh_index !== e.sidx)) begin
          n_bad++;
          $display("FAIL %s: got kind=%0d idx=%h we=%b sh=%b sidx=%h expected kind=%0d idx=%h we=%b sh=%b sidx=%h",
                   e.tag, rsp_kind, rsp_index, rsp_we, rsp_sh_we, rsp_sh_index,
                   e.kind, e.idx, e.we, e.sh, e.sidx);
        end
      end
    end
  end

  // Driver: every task starts and ends just after a rising edge.
  task automatic issue(input logic [23:0] a, input logic w, input logic [1:0] k,
                       input logic [23:0] i, input logic s, input logic [23:0] si, input string tag);
    exp_t e;
    e.kind = k; e.idx = i; e.we = w & (k == K_RAM); e.sh = s; e.sidx = si; e.tag = tag;
    q.push_back(e);
    req_addr = a; req_we = w; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; sw_stb = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [1:0] k, input logic [23:0] i, input string tag);
    issue(a, 1'b0, k, i, 1'b0, 24'h0, tag);
  endtask

  task automatic wr(input logic [23:0] a, input logic [1:0] k, input logic [23:0] i,
                    input logic s, input logic [23:0] si, input string tag);
    issue(a, 1'b1, k, i, s, si, tag);
  endtask

  task automatic sw(input logic [7:0] sel);
    sw_stb = 1'b1; sw_sel = sel;
    @(posedge clk); #1;
    sw_stb = 1'b0;
  endtask

  task automatic shw(input logic [7:0] v);
    shadow_we = 1'b1; shadow_wdata = v;
    @(posedge clk); #1;
    shadow_we = 1'b0;
  endtask

  task automatic stw(input logic [7:0] v);
    state_we = 1'b1; state_wdata = v;
    @(posedge clk); #1;
    state_we = 1'b0;
  endtask

  task automatic st_chk(input logic [7:0] v, input string tag);
    check(state_rdata === v, tag, {16'h0, state_rdata}, {16'h0, v});
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got no finish expected finish");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid === 1'b0, "R1 rsp_valid", {23'h0, rsp_valid}, 24'h0);
    check(req_ready === 1'b1, "R1 req_ready", {23'h0, req_ready}, 24'h1);
    st_chk(8'h00, "R1 state");
    @(posedge clk); #1;
    rd(24'h000300, K_RAM, 24'h000300, "R1 no steering after reset");

    // R3 ROM banks
    rd(24'hFC0000, K_ROM, 24'h000000, "R3 rom first byte");
    rd(24'hFFFFFF, K_ROM, 24'h03FFFF, "R3 rom last byte");
    wr(24'hFC0000, K_ROM, 24'h000000, 1'b0, 24'h0, "R3 rom write dropped");
    // R4 overlay on
    rd(24'h00FFFF, K_ROM, 24'h03FFFF, "R4 bank00 top");
    rd(24'h01FFFF, K_ROM, 24'h03FFFF, "R4 bank01 top");
    rd(24'hE0FFFF, K_ROM, 24'h03FFFF, "R4 bankE0 top");
    rd(24'hE1FFFF, K_ROM, 24'h03FFFF, "R4 bankE1 top");
    rd(24'h00C030, K_NONE, 24'h000000, "R4 io page none");
    wr(24'h00D000, K_ROM, 24'h03D000, 1'b0, 24'h0, "R4 overlay write dropped");
    // R5 fast banks
    wr(24'hE00000, K_RAM, 24'h800000, 1'b0, 24'h0, "R5 bankE0 base");
    wr(24'hE10000, K_RAM, 24'h810000, 1'b0, 24'h0, "R5 bankE1 base");
    // R6 shadowing
    wr(24'h000400, K_RAM, 24'h000400, 1'b1, 24'h800400, "R6 bank00 text shadow");
    wr(24'h010400, K_RAM, 24'h010400, 1'b1, 24'h810400, "R6 bank01 text shadow");
    wr(24'hE10400, K_RAM, 24'h810400, 1'b0, 24'h0, "R6 direct fast write not copied");
    rd(24'h000400, K_RAM, 24'h000400, "R6 read no shadow");
    wr(24'h002000, K_RAM, 24'h002000, 1'b1, 24'h802000, "R6 graphics shadow");
    wr(24'h000800, K_RAM, 24'h000800, 1'b0, 24'h0, "R6 outside video page");

    // R2 and R14 with everything off
    shw(8'h5F);
    wr(24'h000400, K_RAM, 24'h000400, 1'b0, 24'h0, "R2 text no shadow when off");
    rd(24'h00C030, K_RAM, 24'h00C030, "R2 io page linear");
    rd(24'h7FFFFF, K_RAM, 24'h7FFFFF, "R2 top linear");
    wr(24'h3A1234, K_RAM, 24'h3A1234, 1'b0, 24'h0, "R2 mid linear write");
    wr(24'h00FFFF, K_RAM, 24'h00FFFF, 1'b0, 24'h0, "R2 bank00 top as RAM");
    rd(24'h800000, K_NONE, 24'h0, "R14 bank80 unmapped");
    rd(24'hE20000, K_NONE, 24'h0, "R14 bankE2 unmapped");
    wr(24'hFB1234, K_NONE, 24'h0, 1'b0, 24'h0, "R14 bankFB unmapped write");

    shw(8'h40);
    wr(24'h000400, K_RAM, 24'h000400, 1'b1, 24'h800400, "R6 text shadow with overlay off");
    rd(24'h00D000, K_RAM, 24'h00D000, "R4 overlay off gives RAM");
    shw(8'h02);
    wr(24'h002000, K_RAM, 24'h002000, 1'b0, 24'h0, "R6 graphics shadow inhibited");
    wr(24'h000400, K_RAM, 24'h000400, 1'b1, 24'h800400, "R6 text shadow kept");
    rd(24'h00FFFF, K_ROM, 24'h03FFFF, "R4 overlay back on");
    shw(8'h40);

    // R7 steering
    sw(8'h05);
    st_chk(8'h10, "R7 state write-steer");
    wr(24'h000300, K_RAM, 24'h010300, 1'b0, 24'h0, "R7 write to aux");
    rd(24'h000300, K_RAM, 24'h000300, "R7 read stays main");
    wr(24'h000500, K_RAM, 24'h010500, 1'b1, 24'h810500, "R10 steered write shadows to E1");
    sw(8'h04); sw(8'h03);
    st_chk(8'h20, "R7 state read-steer");
    wr(24'h000300, K_RAM, 24'h000300, 1'b0, 24'h0, "R7 write back to main");
    rd(24'h000300, K_RAM, 24'h010300, "R7 read from aux");
    rd(24'h00BFFF, K_RAM, 24'h01BFFF, "R7 top of steered range");
    rd(24'h00C000, K_RAM, 24'h00C000, "R7 above steered range");

    // R8 low area
    rd(24'h000100, K_RAM, 24'h000100, "R8 low area ignores read-steer");
    wr(24'h0001FF, K_RAM, 24'h0001FF, 1'b0, 24'h0, "R8 low area write main");
    sw(8'h09);
    st_chk(8'hA0, "R8 state low toggle");
    rd(24'h000100, K_RAM, 24'h010100, "R8 low area read aux");
    wr(24'h000000, K_RAM, 24'h010000, 1'b0, 24'h0, "R8 low area write aux");

    // R9 paired pages
    sw(8'h01); sw(8'h55);
    st_chk(8'hE0, "R9 state page select");
    wr(24'h000400, K_RAM, 24'h010400, 1'b1, 24'h810400, "R10 paired text write to E1");
    rd(24'h000600, K_RAM, 24'h010600, "R9 paired text read");
    sw(8'h02);
    st_chk(8'hC0, "R9 state read-steer off");
    rd(24'h000600, K_RAM, 24'h010600, "R9 pairing overrides read-steer");
    wr(24'h002000, K_RAM, 24'h002000, 1'b1, 24'h802000, "R9 graphics not paired without toggle");
    sw(8'h57);
    wr(24'h002000, K_RAM, 24'h012000, 1'b1, 24'h812000, "R9 graphics paired");
    rd(24'h003FFF, K_RAM, 24'h013FFF, "R9 graphics paired top");
    sw(8'h05); sw(8'h54);
    st_chk(8'h90, "R9 state page select off");
    wr(24'h000400, K_RAM, 24'h000400, 1'b1, 24'h800400, "R9 pairing overrides write-steer");
    wr(24'h000300, K_RAM, 24'h010300, 1'b0, 24'h0, "R9 general area still steered");
    sw(8'h00);
    wr(24'h000400, K_RAM, 24'h010400, 1'b1, 24'h810400, "R9 pairing off falls to write-steer");

    // R11 strobe and request on the same edge
    drain();
    sw_stb = 1'b1; sw_sel = 8'h04;
    wr(24'h000300, K_RAM, 24'h010300, 1'b0, 24'h0, "R11 same-edge uses old setting");
    wr(24'h000300, K_RAM, 24'h000300, 1'b0, 24'h0, "R11 next request uses new setting");

    // R12 state load
    stw(8'h00);
    st_chk(8'h00, "R12 load zero");
    wr(24'h000100, K_RAM, 24'h000100, 1'b0, 24'h0, "R12 low toggle cleared by load");
    stw(8'h3A);
    st_chk(8'h3A, "R12 load readback");
    rd(24'h000300, K_RAM, 24'h010300, "R12 loaded read-steer");
    wr(24'h000300, K_RAM, 24'h010300, 1'b0, 24'h0, "R12 loaded write-steer");
    drain();
    sw_stb = 1'b1; sw_sel = 8'h09; state_we = 1'b1; state_wdata = 8'hFF;
    @(posedge clk); #1;
    sw_stb = 1'b0; state_we = 1'b0;
    st_chk(8'hFF, "R12 load wins over strobe");
    rd(24'h000100, K_RAM, 24'h010100, "R12 loaded low toggle");
    stw(8'h00);

    // R13 back-pressure
    drain();
    rsp_ready = 1'b0;
    rd(24'h000300, K_RAM, 24'h000300, "R13 stalled first");
    begin
      exp_t e;
      e.kind = K_RAM; e.idx = 24'h7FFFFF; e.we = 1'b0; e.sh = 1'b0; e.sidx = 24'h0;
      e.tag = "R13 second after stall";
      q.push_back(e);
    end
    req_addr = 24'h7FFFFF; req_we = 1'b0; req_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1 && rsp_index === 24'h000300, "R13 held response", rsp_index, 24'h000300);
      check(req_ready === 1'b0, "R13 ready low while stalled", {23'h0, req_ready}, 24'h0);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    drain();
    repeat (3) @(posedge clk);
    check(q.size() == 0, "R13 scoreboard empty", 24'(q.size()), 24'h0);
    finish_run();
  end

endmodule